// File: doc/BRIEF.md
# Convert-Start Gating and Power-Mode Controller

This block is the digital control core of a sampling converter. One asynchronous convert-start input drives all of its timing. A rising edge on that input powers the block up and launches a fixed-length internal power-up pulse. That pulse is ORed with the input to form a combined start signal. A conversion begins when the combined signal falls, so whichever of the two falls later sets the sampling instant.

During the conversion the block holds a busy flag high. It resolves an 8-bit straight-binary code by successive approximation. It presents each trial code to an external DAC and reads back a single comparator bit. When busy falls, the final code is latched into an output register.

The level of the start input at that moment sets the power mode:
- If the input is high, the block stays powered for high-rate sampling.
- If the input is low, the block drops into power-down automatically.

An active-low chip-select/read port exposes the result register and drives a data-enable output. The port works whether or not the block is powered.

Top module: `sar_start_ctrl`

## Requirements
- R1: After reset, `busy`, `powered` and `data_oe` are 0, `data_out` is 0 and the stored result is 0.
- R2: The start input passes through a two-flop synchronizer. Suppose the input is raised before clock edge 0, lowered before edge H, and the block is idle. Then `powered` becomes 1 at edge 2, and `busy` rises at edge max(H+2, PWRUP_CYC+3). With the input held high, no conversion starts until the input falls.
- R3: `busy` stays high for exactly NBITS*BIT_CYC clock cycles per conversion.
- R4: Bits are tried MSB first, one trial every BIT_CYC cycles. During each trial `dac_code` holds the bits kept so far plus the bit under trial set to 1. `cmp_in`=1 keeps the bit and `cmp_in`=0 clears it. With an ideal comparator (`cmp_in` = input code >= `dac_code`), the result equals the input code.
- R5: If the start input is high when `busy` falls, `powered` stays 1.
- R6: If the start input is low when `busy` falls, `powered` goes to 0 on the same edge on which `busy` falls.
- R7: `data_oe` is 1 only while `cs_n`=0, `rd_n`=0 and `busy`=0. `data_out` equals the result while `data_oe` is 1 and is 0 otherwise.
- R8: If an access (`cs_n`=0 and `rd_n`=0) is active when `busy` rises, `data_oe` stays 0 until `cs_n` or `rd_n` returns high, even after `busy` falls.
- R9: The result register keeps its value from one fall of `busy` to the next, and it can be read while `powered` is 0.
- R10: While `busy` is high, a start rise launches no power-up pulse and a fall of the combined start signal starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_in | input | 1 | External convert-start, asynchronous |
| cmp_in | input | 1 | Comparator result for the current trial (1 = keep bit) |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| dac_code | output | NBITS | Trial code for the external DAC |
| busy | output | 1 | High while a conversion runs |
| powered | output | 1 | High while the block is powered up |
| data_oe | output | 1 | Data bus drive enable |
| data_out | output | NBITS | Result register contents while enabled, otherwise 0 |

## Verification
Suppose the power-up pulse counter or the combined-signal edge detector holds the wrong state. The cycle on which `busy` rises then moves, and that shift shows within a few cycles of the start input falling. A wrong sequencer count or bit index does two things: it changes how long `busy` stays high, and it corrupts the code read back after the conversion ends. An exhaustive sweep over all 256 comparator thresholds exposes both. A wrong power-mode or read-abort flag shows on `powered` or `data_oe` on the first cycle after `busy` falls.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_t;

  // counter width able to hold the value n
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sar_start_gate.sv
module sar_start_gate
  import sar_ctrl_pkg::*;
#(
  parameter int PWRUP_CYC = 375
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_in,
  input  logic busy,
  output logic s_start,
  output logic rise_ok,
  output logic gated_fall
);
  localparam int PW = cnt_w(PWRUP_CYC);

  logic [1:0]    sync_q;
  logic          prev_q;
  logic          gated_q;
  logic [PW-1:0] pulse_cnt;
  logic          pulse_act;
  logic          gated;

  assign s_start    = sync_q[1];
  assign rise_ok    = s_start & ~prev_q & ~busy;
  assign pulse_act  = (pulse_cnt != '0);
  assign gated      = s_start | pulse_act;
  assign gated_fall = gated_q & ~gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      prev_q    <= 1'b0;
      gated_q   <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      sync_q  <= {sync_q[0], start_in};
      prev_q  <= s_start;
      gated_q <= gated;
      if (rise_ok)
        pulse_cnt <= PW'(PWRUP_CYC);
      else if (pulse_act)
        pulse_cnt <= pulse_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_ctrl_pkg::*;
#(
  parameter int NBITS   = 8,
  parameter int BIT_CYC = 141
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             cmp_in,
  output logic             busy,
  output logic             done,
  output logic [NBITS-1:0] code,
  output logic [NBITS-1:0] result
);
  localparam int CW = cnt_w(BIT_CYC);
  localparam int IW = cnt_w(NBITS - 1);

  seq_state_t    state;
  logic [CW-1:0] cyc_cnt;
  logic [IW-1:0] bit_idx;
  logic          step;

  // next trial code: settle bit i from the comparator, raise bit i-1
  function automatic logic [NBITS-1:0] sar_next(input logic [NBITS-1:0] c,
                                                input logic [IW-1:0] i,
                                                input logic keep);
    logic [NBITS-1:0] n;
    n = c;
    if (!keep) n[i] = 1'b0;
    if (i != '0) n[i - 1'b1] = 1'b1;
    return n;
  endfunction

  assign busy = (state == SEQ_RUN);
  assign step = busy && (cyc_cnt == CW'(BIT_CYC - 1));
  assign done = step && (bit_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      cyc_cnt <= '0;
      bit_idx <= '0;
      code    <= '0;
      result  <= '0;
    end else if (go) begin
      state   <= SEQ_RUN;
      cyc_cnt <= '0;
      bit_idx <= IW'(NBITS - 1);
      code    <= {1'b1, {(NBITS-1){1'b0}}};
    end else if (busy) begin
      if (step) begin
        cyc_cnt <= '0;
        code    <= sar_next(code, bit_idx, cmp_in);
        if (done) begin
          result <= sar_next(code, bit_idx, cmp_in);
          state  <= SEQ_IDLE;
        end else begin
          bit_idx <= bit_idx - 1'b1;
        end
      end else begin
        cyc_cnt <= cyc_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_rd_port.sv
module sar_rd_port #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             busy,
  input  logic [NBITS-1:0] result,
  output logic             data_oe,
  output logic [NBITS-1:0] data_out
);
  logic access;
  logic busy_q;
  logic abort_q;

  assign access   = ~cs_n & ~rd_n;
  assign data_oe  = access & ~busy & ~abort_q;
  assign data_out = data_oe ? result : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      busy_q <= busy;
      if (!access)
        abort_q <= 1'b0;
      else if (busy && !busy_q)
        abort_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sar_start_ctrl.sv
module sar_start_ctrl #(
  parameter int NBITS     = 8,
  parameter int PWRUP_CYC = 375,
  parameter int BIT_CYC   = 141
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_in,
  input  logic             cmp_in,
  input  logic             cs_n,
  input  logic             rd_n,
  output logic [NBITS-1:0] dac_code,
  output logic             busy,
  output logic             powered,
  output logic             data_oe,
  output logic [NBITS-1:0] data_out
);
  logic             s_start;
  logic             rise_ok;
  logic             gated_fall;
  logic             conv_go;
  logic             seq_done;
  logic [NBITS-1:0] result_q;

  assign conv_go = gated_fall & ~busy & powered;

  sar_start_gate #(.PWRUP_CYC(PWRUP_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .start_in(start_in), .busy(busy),
    .s_start(s_start), .rise_ok(rise_ok), .gated_fall(gated_fall)
  );

  sar_seq #(.NBITS(NBITS), .BIT_CYC(BIT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(conv_go), .cmp_in(cmp_in),
    .busy(busy), .done(seq_done), .code(dac_code), .result(result_q)
  );

  sar_rd_port #(.NBITS(NBITS)) u_rd (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .busy(busy),
    .result(result_q), .data_oe(data_oe), .data_out(data_out)
  );

  // power state: up on an accepted rise, mode chosen at end of conversion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      powered <= 1'b0;
    else if (rise_ok)
      powered <= 1'b1;
    else if (seq_done)
      powered <= s_start;
  end
endmodule

// File: rtl/sar_start_ctrl_chk.sv
module sar_start_ctrl_chk
  import sar_ctrl_pkg::*;
#(
  parameter int NBITS   = 8,
  parameter int BIT_CYC = 141
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             powered,
  input logic             data_oe,
  input logic             cs_n,
  input logic             rd_n,
  input logic             s_start,
  input logic             gated_fall,
  input logic [NBITS-1:0] result
);
  localparam int CONV = NBITS * BIT_CYC;
  localparam int RW   = cnt_w(CONV) + 1;

  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else        run_cnt <= busy ? run_cnt + 1'b1 : '0;
  end

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == RW'(CONV)));

  p_start_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(gated_fall));

  p_busy_powered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> powered);

  p_stay_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(s_start)) |-> powered);

  p_auto_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(s_start)) |-> !powered);

  p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!cs_n && !rd_n && !busy));

  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(result));
endmodule

bind sar_start_ctrl sar_start_ctrl_chk #(.NBITS(NBITS), .BIT_CYC(BIT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .powered(powered),
  .data_oe(data_oe), .cs_n(cs_n), .rd_n(rd_n), .s_start(s_start),
  .gated_fall(gated_fall), .result(result_q)
);

// File: tb/sar_start_ctrl_bench.sv
`timescale 1ns/1ps
module sar_start_ctrl_bench;
  localparam int N  = 8;
  localparam int P  = 6;
  localparam int B  = 2;
  localparam int NB = N * B;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_in = 1'b0;
  logic         cs_n = 1'b1;
  logic         rd_n = 1'b1;
  logic [N-1:0] vin = '0;
  logic         cmp_in;
  logic [N-1:0] dac_code;
  logic         busy, powered, data_oe;
  logic [N-1:0] data_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  // ideal comparator: keep the trial bit when input >= trial code
  assign cmp_in = (vin >= dac_code);

  sar_start_ctrl #(.NBITS(N), .PWRUP_CYC(P), .BIT_CYC(B)) u_sar_start_ctrl (
    .clk(clk), .rst_n(rst_n), .start_in(start_in), .cmp_in(cmp_in),
    .cs_n(cs_n), .rd_n(rd_n), .dac_code(dac_code), .busy(busy),
    .powered(powered), .data_oe(data_oe), .data_out(data_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_read(output logic oe, output logic [N-1:0] d);
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    oe = data_oe; d = data_out;
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  // start raised now, lowered after h negedges; poke>0 pulses start during busy
  task automatic run_conv(input int h, input int poke, output int lat,
                          output int len, output logic pwr);
    int k;
    start_in = 1'b1;
    lat = -1;
    k = 0;
    while (k < 200) begin
      @(negedge clk);
      k++;
      if (k == 2) chk("R2 not yet powered", powered, 0);
      if (k == 3) chk("R2 powered after rise", powered, 1);
      if (busy) begin lat = k; break; end
      if (k == h) start_in = 1'b0;
    end
    len = (lat > 0) ? 1 : 0;
    while (lat > 0 && len < 200) begin
      if (poke > 0 && len == poke) start_in = 1'b1;
      if (poke > 0 && len == poke + 2) start_in = 1'b0;
      @(negedge clk);
      if (busy) len++;
      else break;
    end
    pwr = powered;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat, len, k, exp_lat;
    logic pwr, oe;
    logic [N-1:0] d;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 powered", powered, 0);
    chk("R1 data_oe idle", data_oe, 0);
    do_read(oe, d);
    chk("R1 oe on read", oe, 1);
    chk("R1 reset result", d, 0);

    // R7 partial selects give no drive
    cs_n = 1'b0; rd_n = 1'b1;
    @(negedge clk);
    chk("R7 cs only", data_oe, 0);
    chk("R7 cs only data", data_out, 0);
    cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    chk("R7 rd only", data_oe, 0);
    rd_n = 1'b1;
    @(negedge clk);

    // exhaustive sweep in automatic power-down mode
    for (int v = 0; v < 256; v++) begin
      int h;
      vin = N'(v);
      h = (v % 8) + 1;
      exp_lat = ((h + 2 > P + 3) ? h + 2 : P + 3) + 1;
      run_conv(h, 0, lat, len, pwr);
      chk("R2 start latency", lat, exp_lat);
      chk("R3 busy length", len, NB);
      chk("R6 auto power-down", pwr, 0);
      do_read(oe, d);
      chk("R9 read while down oe", oe, 1);
      chk("R4 result code", d, v);
    end

    // high-speed mode with a start rise during the conversion
    vin = 8'hA5;
    start_in = 1'b1;
    repeat (12) @(negedge clk);
    chk("R2 held start waits", busy, 0);
    start_in = 1'b0;
    k = 0;
    while (k < 50) begin
      @(negedge clk); k++;
      if (busy) break;
    end
    chk("R2 start on late external fall", k, 3);
    len = 1;
    while (len < 200) begin
      if (len == 12) start_in = 1'b1;
      @(negedge clk);
      if (busy) len++;
      else break;
    end
    chk("R3 busy length mode1", len, NB);
    chk("R5 stays powered", powered, 1);
    vin = 8'h3C;
    start_in = 1'b0;
    k = 0;
    while (k < 50) begin
      @(negedge clk); k++;
      if (busy) break;
    end
    chk("R10 rise in busy launched no pulse", k, 3);
    len = 1;
    while (len < 200) begin
      @(negedge clk);
      if (busy) len++;
      else break;
    end
    chk("R6 down after second", powered, 0);
    do_read(oe, d);
    chk("R4 mode1 result", d, 8'h3C);

    // combined-signal fall during busy starts nothing
    vin = 8'h5A;
    run_conv(1, 4, lat, len, pwr);
    chk("R10 busy length with poke", len, NB);
    k = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy || powered) k++;
    end
    chk("R10 no restart, stays down", k, 0);
    do_read(oe, d);
    chk("R4 poke result", d, 8'h5A);

    // read held across a conversion start is cut off
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    chk("R9 held read old value", data_out, 8'h5A);
    vin = 8'hC3;
    run_conv(1, 0, lat, len, pwr);
    chk("R8 oe off after busy", data_oe, 0);
    chk("R8 data off after busy", data_out, 0);
    rd_n = 1'b1;
    @(negedge clk);
    rd_n = 1'b0;
    @(negedge clk);
    chk("R8 re-access oe", data_oe, 1);
    chk("R8 re-access data", data_out, 8'hC3);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // R7 enable only without busy, sampled every cycle
  always @(negedge clk) begin
    if (rst_n && data_oe && busy) begin
      n_bad++;
      $display("FAIL R7 oe during busy actual=%0d expected=%0d", 1, 0);
    end
  end
endmodule